// File: doc/BRIEF.md
# Chained 64-bit Block Cipher Context Sequencer

This block sits between a 32-bit host register port and an external 64-bit block function. It holds the job context: three 64-bit keys, a 64-bit chaining value (the initialization vector), a control word and a byte counter. It then runs each data block through one pass of the block function in single mode, or three passes in triple mode. Around those passes it applies ECB, CBC or CFB chaining.

The host first loads the context while the context-free flag is set. Writing a non-zero byte count starts the job. For each block, the host writes a low and a high data word while input-ready is set. It then waits for output-ready and reads the two result words back. The job ends once the counter has reached zero and the last result has been read. At that point the context-free flag returns and the next context may be loaded.

The block function is outside this block. It receives a start pulse with a 64-bit input, a key and a direction. It returns a done pulse with the 64-bit result after any latency of at least one cycle.

Top module: `cctx_top`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (context free, all other bits 0), and the length address reads zero.
- R2: Word addresses are: key 1 low/high 0/1, key 2 low/high 2/3, key 3 low/high 4/5, chaining value low/high 6/7, control 8, length 9, data low/high 10/11. Keys and the chaining value read back as stored.
- R3: Control word layout: bits 5:4 chaining mode (0 ECB, 1 CBC, 2 CFB, 3 reserved), bit 3 triple mode, bit 2 direction (1 encrypt, 0 decrypt), bit 1 input-ready, bit 0 output-ready, bit 31 context-free. All other bits read 0.
- R4: A write of a non-zero value to the length address while context-free is set clears context-free and sets input-ready on the next cycle. A write of zero starts nothing. The length address always reads zero.
- R5: A block starts only on a high data word write while input-ready is set. A low word write alone starts nothing. Data writes while input-ready is clear are ignored.
- R6: In single mode the block function runs once, with key 1, in the direction given by bit 2.
- R7: In triple mode, encryption runs encrypt/key 1, decrypt/key 2, encrypt/key 3. Decryption runs decrypt/key 3, encrypt/key 2, decrypt/key 1.
- R8: In ECB mode and in reserved mode 3, the result is the block function applied to the data, and the chaining value is left unchanged.
- R9: In CBC encryption the data is XORed with the chaining value before the passes, and the result becomes the new chaining value. In CBC decryption the pass output is XORed with the chaining value, and the incoming data becomes the new chaining value.
- R10: In CFB mode the passes always run forward on the chaining value, and the result is their output XORed with the data. The new chaining value is the result when encrypting and the incoming data when decrypting.
- R11: Output-ready sets after the final pass and clears after the high result word is read. Each block lowers the count by 8, saturating at zero. A non-zero remainder raises input-ready again.
- R12: Context-free returns to 1 only when the count is zero and the final high result word has been read.
- R13: While context-free is 0, writes to keys, chaining value, control and length are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (has effect only on data high) |
| addr | input | AW | Host word address |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data, combinational from addr |
| bf_start | output | 1 | One-cycle start pulse to the block function |
| bf_din | output | BW | Block function input |
| bf_key | output | BW | Key for the current pass |
| bf_encrypt | output | 1 | Pass direction, 1 = forward |
| bf_done | input | 1 | Block function result valid |
| bf_dout | input | BW | Block function result |

## Verification
The checker tests several things on every cycle:
- start pulses last exactly one cycle and come only while no flag is raised;
- a length write issued while context-free is set moves the block into the input-ready state;
- output-ready rises only right after a done pulse;
- context-free rises only after a high result read;
- key 1 stays frozen while a job runs.

The bench scenarios cover the rest: the chaining arithmetic of each mode, the key order of the triple passes, the saturating byte count, and the ignored writes. Each scenario compares results against a separately written reference model.

// File: rtl/cctx_pkg.sv
package cctx_pkg;

  localparam int BLK_W = 64;

  typedef enum logic [1:0] {
    CH_ECB = 2'd0,
    CH_CBC = 2'd1,
    CH_CFB = 2'd2,
    CH_RSV = 2'd3
  } chain_e;

  typedef enum logic [2:0] {
    ST_FREE,
    ST_WAIT_IN,
    ST_ISSUE,
    ST_BUSY,
    ST_OUT
  } seq_st_e;

  // word addresses (R2)
  localparam int A_IV_LO = 6;
  localparam int A_IV_HI = 7;
  localparam int A_CTRL  = 8;
  localparam int A_LEN   = 9;
  localparam int A_DLO   = 10;
  localparam int A_DHI   = 11;

  // block input before the passes
  function automatic logic [BLK_W-1:0] chain_pre(chain_e m, logic enc,
                                                 logic [BLK_W-1:0] d,
                                                 logic [BLK_W-1:0] cv);
    case (m)
      CH_CBC:  return enc ? (d ^ cv) : d;
      CH_CFB:  return cv;
      default: return d;
    endcase
  endfunction

  // host-visible result after the passes
  function automatic logic [BLK_W-1:0] chain_post(chain_e m, logic enc,
                                                  logic [BLK_W-1:0] d,
                                                  logic [BLK_W-1:0] cv,
                                                  logic [BLK_W-1:0] res);
    case (m)
      CH_CBC:  return enc ? res : (res ^ cv);
      CH_CFB:  return res ^ d;
      default: return res;
    endcase
  endfunction

  // chaining value for the following block
  function automatic logic [BLK_W-1:0] chain_next(chain_e m, logic enc,
                                                  logic [BLK_W-1:0] d,
                                                  logic [BLK_W-1:0] cv,
                                                  logic [BLK_W-1:0] o);
    case (m)
      CH_CBC, CH_CFB: return enc ? o : d;
      default:        return cv;
    endcase
  endfunction

  // key index for a pass: single uses key 1, triple walks keys by direction
  function automatic logic [1:0] pass_key(logic [1:0] p, logic triple, logic fwd);
    if (!triple) return 2'd0;
    return fwd ? p : (2'd2 - p);
  endfunction

  // pass direction: middle pass of a triple run is inverted
  function automatic logic pass_enc(logic [1:0] p, logic triple, logic fwd);
    if (!triple) return fwd;
    return (p == 2'd1) ? !fwd : fwd;
  endfunction

  function automatic logic [31:0] len_after(logic [31:0] len, logic [31:0] step);
    return (len > step) ? (len - step) : 32'd0;
  endfunction

endpackage

// File: rtl/cctx_regfile.sv
module cctx_regfile
  import cctx_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 32,
  parameter int BW   = 64,
  parameter int NKEY = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 ctx_free,
  output logic [NKEY*BW-1:0]   key_flat,
  output chain_e               mode,
  output logic                 triple,
  output logic                 enc_dir
);
  localparam int WPB = BW / DW;

  logic ctx_wr;
  assign ctx_wr = wr_en && ctx_free;

  for (genvar w = 0; w < NKEY * WPB; w++) begin : g_keyw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        key_flat[w*DW +: DW] <= '0;
      else if (ctx_wr && addr == AW'(w))
        key_flat[w*DW +: DW] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= CH_ECB;
      triple  <= 1'b0;
      enc_dir <= 1'b0;
    end else if (ctx_wr && addr == AW'(A_CTRL)) begin
      mode    <= chain_e'(wdata[5:4]);
      triple  <= wdata[3];
      enc_dir <= wdata[2];
    end
  end
endmodule

// File: rtl/cctx_keysel.sv
module cctx_keysel
  import cctx_pkg::*;
#(
  parameter int BW   = 64,
  parameter int NKEY = 3
) (
  input  logic [NKEY*BW-1:0] key_flat,
  input  logic [1:0]         pass,
  input  logic               triple,
  input  logic               fwd,
  output logic [BW-1:0]      key,
  output logic               enc
);
  logic [1:0] idx;
  always_comb begin
    idx = pass_key(pass, triple, fwd);
    enc = pass_enc(pass, triple, fwd);
    key = '0;
    for (int i = 0; i < NKEY; i++)
      if (idx == 2'(i)) key = key_flat[i*BW +: BW];
  end
endmodule

// File: rtl/cctx_seq.sv
module cctx_seq
  import cctx_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int BW = 64,
  parameter int LW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  chain_e          mode,
  input  logic            triple,
  input  logic            enc_dir,
  input  logic            bf_done,
  input  logic [BW-1:0]   bf_dout,
  output logic            bf_start,
  output logic [BW-1:0]   bf_din,
  output logic [1:0]      pass,
  output logic            fwd_eff,
  output logic            in_ready,
  output logic            out_ready,
  output logic            ctx_free,
  output logic [BW-1:0]   cv,
  output logic [BW-1:0]   result
);
  localparam logic [LW-1:0] STEP = LW'(BW / 8);

  seq_st_e          st_q;
  logic [LW-1:0]    len_q;
  logic [DW-1:0]    dlo_q;
  logic [BW-1:0]    blk_q, work_q;

  logic len_wr, dlo_wr, dhi_wr, hi_rd, last_pass, fin;
  logic [BW-1:0] blk_new, res_out;

  assign len_wr    = wr_en && addr == AW'(A_LEN) && st_q == ST_FREE && wdata != '0;
  assign dlo_wr    = wr_en && addr == AW'(A_DLO) && st_q == ST_WAIT_IN;
  assign dhi_wr    = wr_en && addr == AW'(A_DHI) && st_q == ST_WAIT_IN;
  assign hi_rd     = rd_en && addr == AW'(A_DHI) && st_q == ST_OUT;
  assign last_pass = pass == (triple ? 2'd2 : 2'd0);
  assign fin       = st_q == ST_BUSY && bf_done && last_pass;
  assign blk_new   = {wdata, dlo_q};
  assign res_out   = chain_post(mode, enc_dir, blk_q, cv, bf_dout);

  assign fwd_eff   = (mode == CH_CFB) ? 1'b1 : enc_dir;
  assign bf_start  = st_q == ST_ISSUE;
  assign bf_din    = work_q;
  assign in_ready  = st_q == ST_WAIT_IN;
  assign out_ready = st_q == ST_OUT;
  assign ctx_free  = st_q == ST_FREE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FREE;
      len_q  <= '0;
      dlo_q  <= '0;
      blk_q  <= '0;
      work_q <= '0;
      cv     <= '0;
      result <= '0;
      pass   <= '0;
    end else begin
      case (st_q)
        ST_FREE: begin
          if (wr_en && addr == AW'(A_IV_LO)) cv[DW-1:0]  <= wdata;
          if (wr_en && addr == AW'(A_IV_HI)) cv[BW-1:DW] <= wdata;
          if (len_wr) begin
            len_q <= wdata;
            st_q  <= ST_WAIT_IN;
          end
        end
        ST_WAIT_IN: begin
          if (dlo_wr) dlo_q <= wdata;
          if (dhi_wr) begin
            blk_q  <= blk_new;
            work_q <= chain_pre(mode, enc_dir, blk_new, cv);
            pass   <= '0;
            st_q   <= ST_ISSUE;
          end
        end
        ST_ISSUE: st_q <= ST_BUSY;
        ST_BUSY: begin
          if (fin) begin
            result <= res_out;
            cv     <= chain_next(mode, enc_dir, blk_q, cv, res_out);
            len_q  <= len_after(len_q, STEP);
            st_q   <= ST_OUT;
          end else if (bf_done) begin
            work_q <= bf_dout;
            pass   <= pass + 2'd1;
            st_q   <= ST_ISSUE;
          end
        end
        ST_OUT: begin
          if (hi_rd) st_q <= (len_q == '0) ? ST_FREE : ST_WAIT_IN;
        end
        default: st_q <= ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/cctx_top.sv
module cctx_top
  import cctx_pkg::*;
#(
  parameter int AW   = 4,
  parameter int DW   = 32,
  parameter int BW   = BLK_W,
  parameter int LW   = 32,
  parameter int NKEY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            bf_start,
  output logic [BW-1:0]   bf_din,
  output logic [BW-1:0]   bf_key,
  output logic            bf_encrypt,
  input  logic            bf_done,
  input  logic [BW-1:0]   bf_dout
);
  localparam int WPB = BW / DW;

  logic [NKEY*BW-1:0] key_flat;
  chain_e             mode;
  logic               triple, enc_dir, fwd_eff;
  logic [1:0]         pass;
  logic [BW-1:0]      cv, result;

  // named event wires for the checker
  logic               in_rdy_w, out_rdy_w, ctx_free_w;
  logic [BW-1:0]      key1_w;
  assign key1_w = key_flat[BW-1:0];

  cctx_regfile #(.AW(AW), .DW(DW), .BW(BW), .NKEY(NKEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctx_free(ctx_free_w), .key_flat(key_flat), .mode(mode),
    .triple(triple), .enc_dir(enc_dir)
  );

  cctx_seq #(.AW(AW), .DW(DW), .BW(BW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .mode(mode), .triple(triple), .enc_dir(enc_dir),
    .bf_done(bf_done), .bf_dout(bf_dout), .bf_start(bf_start),
    .bf_din(bf_din), .pass(pass), .fwd_eff(fwd_eff),
    .in_ready(in_rdy_w), .out_ready(out_rdy_w), .ctx_free(ctx_free_w),
    .cv(cv), .result(result)
  );

  cctx_keysel #(.BW(BW), .NKEY(NKEY)) u_ksel (
    .key_flat(key_flat), .pass(pass), .triple(triple), .fwd(fwd_eff),
    .key(bf_key), .enc(bf_encrypt)
  );

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NKEY * WPB; i++)
      if (addr == AW'(i)) rdata = key_flat[i*DW +: DW];
    case (int'(addr))
      A_IV_LO: rdata = cv[DW-1:0];
      A_IV_HI: rdata = cv[BW-1:DW];
      A_CTRL: begin
        rdata       = '0;
        rdata[DW-1] = ctx_free_w;
        rdata[5:4]  = mode;
        rdata[3]    = triple;
        rdata[2]    = enc_dir;
        rdata[1]    = in_rdy_w;
        rdata[0]    = out_rdy_w;
      end
      A_LEN:   rdata = '0;
      A_DLO:   rdata = result[DW-1:0];
      A_DHI:   rdata = result[BW-1:DW];
      default: ;
    endcase
  end
endmodule

// File: rtl/cctx_checker.sv
module cctx_checker #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int BW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          bf_start,
  input logic          bf_done,
  input logic          in_ready,
  input logic          out_ready,
  input logic          ctx_free,
  input logic [BW-1:0] key1
);
  localparam logic [AW-1:0] LEN_A = AW'(cctx_pkg::A_LEN);
  localparam logic [AW-1:0] DHI_A = AW'(cctx_pkg::A_DHI);

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bf_start |=> !bf_start);

  assert_start_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bf_start |-> (!in_ready && !out_ready && !ctx_free));

  assert_len_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == LEN_A && wdata != '0 && ctx_free) |=> (in_ready && !ctx_free));

  assert_outrdy_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> $past(bf_done));

  assert_free_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctx_free) |-> $past(rd_en && addr == DHI_A && out_ready));

  assert_key_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_free |=> $stable(key1));
endmodule

bind cctx_top cctx_checker #(.AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .bf_start(bf_start), .bf_done(bf_done),
  .in_ready(in_rdy_w), .out_ready(out_rdy_w), .ctx_free(ctx_free_w),
  .key1(key1_w)
);

// File: tb/test_cctx_top.sv
module test_cctx_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        bf_start, bf_encrypt;
  logic [63:0] bf_din, bf_key;
  logic        bf_done;
  logic [63:0] bf_dout;

  int total = 0, bad = 0;
  logic [63:0] K1 = 64'h0123_4567_89ab_cdef;
  logic [63:0] K2 = 64'hfeed_face_cafe_beef;
  logic [63:0] K3 = 64'h1357_9bdf_2468_ace0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cctx_top i_cctx_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bf_start(bf_start), .bf_din(bf_din),
    .bf_key(bf_key), .bf_encrypt(bf_encrypt), .bf_done(bf_done),
    .bf_dout(bf_dout)
  );

  function automatic logic [63:0] fe(logic [63:0] x, logic [63:0] k);
    logic [63:0] t = x ^ k;
    return {t[50:0], t[63:51]} + k;
  endfunction
  function automatic logic [63:0] fd(logic [63:0] y, logic [63:0] k);
    logic [63:0] t = y - k;
    return {t[12:0], t[63:13]} ^ k;
  endfunction

  // stand-in block function, 3 cycle latency
  logic [1:0]  bcnt;
  logic [63:0] bres;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= 0; bf_done <= 0; bf_dout <= 0; bres <= 0;
    end else begin
      bf_done <= 0;
      if (bf_start) begin
        bcnt <= 2;
        bres <= bf_encrypt ? fe(bf_din, bf_key) : fd(bf_din, bf_key);
      end else if (bcnt != 0) begin
        bcnt <= bcnt - 1;
        if (bcnt == 1) begin bf_done <= 1; bf_dout <= bres; end
      end
    end
  end

  function automatic logic [63:0] ref_cipher(logic [63:0] x, logic t, logic e);
    if (!t) return e ? fe(x, K1) : fd(x, K1);
    if (e)  return fe(fd(fe(x, K1), K2), K3);
    return fd(fe(fd(x, K3), K2), K1);
  endfunction

  task automatic ref_blk(input logic [1:0] m, input logic t, input logic e,
                         input logic [63:0] d, inout logic [63:0] c,
                         output logic [63:0] o);
    case (m)
      2'd1: if (e) begin o = ref_cipher(d ^ c, t, 1); c = o; end
            else   begin o = ref_cipher(d, t, 0) ^ c; c = d; end
      2'd2: begin o = ref_cipher(c, t, 1) ^ d; c = e ? o : d; end
      default: o = ref_cipher(d, t, e);
    endcase
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic wait_bit(input int b, input string req);
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      rd(4'd8, v);
      if (v[b]) return;
    end
    check(req, 0, 1);
  endtask

  function automatic logic [31:0] mk_ctrl(logic [1:0] m, logic t, logic e);
    return {26'd0, m, t, e, 2'b00};
  endfunction

  task automatic load_ctx(input logic [63:0] iv, input logic [31:0] c);
    wr(0, K1[31:0]); wr(1, K1[63:32]); wr(2, K2[31:0]); wr(3, K2[63:32]);
    wr(4, K3[31:0]); wr(5, K3[63:32]); wr(6, iv[31:0]); wr(7, iv[63:32]);
    wr(8, c);
  endtask

  task automatic run_block(input logic [63:0] pt, output logic [63:0] ct, input string req);
    logic [31:0] lo, hi;
    wait_bit(1, req);
    wr(10, pt[31:0]); wr(11, pt[63:32]);
    wait_bit(0, req);
    rd(10, lo); rd(11, hi);
    ct = {hi, lo};
  endtask

  // run a whole job and compare every block with the model
  task automatic run_job(input logic [1:0] m, input logic t, input logic e,
                         input logic [63:0] iv, input int nblk,
                         input logic [63:0] seed, input string req,
                         inout logic [63:0] blocks [4]);
    logic [63:0] c, o, got;
    logic [31:0] v;
    c = iv;
    load_ctx(iv, mk_ctrl(m, t, e));
    wr(9, 32'(nblk * 8));
    for (int i = 0; i < nblk; i++) begin
      if (seed != 0) blocks[i] = seed ^ (64'h1111_0000_2222_0001 * 64'(i + 3));
      ref_blk(m, t, e, blocks[i], c, o);
      run_block(blocks[i], got, req);
      check(req, got, o);
      blocks[i] = got;
    end
    rd(8, v);
    check({req, " R12 free at end"}, v, {1'b1, 31'(mk_ctrl(m, t, e))});
    rd(6, v); check({req, " R2 cv lo"}, v, c[31:0]);
    rd(7, v); check({req, " R2 cv hi"}, v, c[63:32]);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8, v); check("R1 ctrl", v, 32'h8000_0000);
    rd(9, v); check("R1 len", v, 0);
  endtask

  task automatic t_ecb_single;
    logic [63:0] b [4];
    logic [31:0] v;
    logic [63:0] got;
    run_job(2'd0, 0, 1, 64'h0, 3, 64'hdead_0000_beef_0001, "R6 R8 ecb enc", b);
    // R11: mid-job flag sequence, R4: length reads 0 while busy
    load_ctx(64'h0, mk_ctrl(0, 0, 0));
    wr(9, 16);
    rd(8, v); check("R4 start flags", v, 32'h0000_0002);
    rd(9, v); check("R4 len reads zero", v, 0);
    run_block(b[0], got, "R6 ecb dec");
    check("R6 ecb dec 0", got, 64'hdead_0000_beef_0001 ^ (64'h1111_0000_2222_0001 * 64'd3));
    rd(8, v); check("R11 input ready again", v, 32'h0000_0002);
    run_block(b[1], got, "R6 ecb dec");
    rd(8, v); check("R12 free", v, 32'h8000_0000);
  endtask

  task automatic t_cbc_triple;
    logic [63:0] b [4];
    logic [63:0] iv = 64'h0f1e_2d3c_4b5a_6978;
    logic [63:0] pt0;
    run_job(2'd1, 1, 1, iv, 3, 64'h5555_aaaa_0000_ffff, "R7 R9 cbc3 enc", b);
    pt0 = 64'h5555_aaaa_0000_ffff ^ (64'h1111_0000_2222_0001 * 64'd3);
    run_job(2'd1, 1, 0, iv, 3, 0, "R7 R9 cbc3 dec", b);
    check("R9 cbc round trip", b[0], pt0);
  endtask

  task automatic t_cfb;
    logic [63:0] b [4];
    logic [63:0] iv = 64'h7777_1234_abcd_0042;
    logic [63:0] pt1;
    run_job(2'd2, 0, 1, iv, 2, 64'h3c3c_0f0f_c3c3_f0f0, "R10 cfb enc", b);
    pt1 = 64'h3c3c_0f0f_c3c3_f0f0 ^ (64'h1111_0000_2222_0001 * 64'd4);
    run_job(2'd2, 0, 0, iv, 2, 0, "R10 cfb dec", b);
    check("R10 cfb round trip", b[1], pt1);
    run_job(2'd2, 1, 0, iv, 2, 64'h0102_0304_0506_0708, "R10 R7 cfb3 dec", b);
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    logic [63:0] got;
    logic [63:0] d = 64'h0000_1111_2222_3333;
    load_ctx(64'h0, mk_ctrl(0, 0, 1));
    wr(9, 8);
    wr(0, 32'hffff_ffff);
    rd(0, v); check("R13 key write ignored", v, K1[31:0]);
    wr(8, mk_ctrl(1, 1, 0));
    rd(8, v); check("R13 ctrl write ignored", v, 32'h0000_0006);
    wr(6, 32'h1234_5678);
    rd(6, v); check("R13 iv write ignored", v, 0);
    wr(9, 800);
    wr(10, d[31:0]);
    repeat (6) @(posedge clk);
    rd(8, v); check("R5 low word alone", v, 32'h0000_0006);
    wr(11, d[63:32]);
    wait_bit(0, "R5 start");
    wr(11, 32'hffff_0000);
    rd(8, v); check("R5 write while busy ignored", v, 32'h0000_0005);
    rd(10, v); got[31:0] = v; rd(11, v); got[63:32] = v;
    check("R5 R6 result", got, fe(d, K1));
    rd(8, v); check("R13 length rewrite ignored", v, 32'h8000_0004);
  endtask

  task automatic t_partial;
    logic [31:0] v;
    logic [63:0] got;
    load_ctx(64'h0, mk_ctrl(3, 0, 1));
    rd(8, v); check("R3 mode 3 readback", v, 32'h8000_0034);
    wr(9, 5);
    run_block(64'h9999_8888_7777_6666, got, "R8 mode3");
    check("R8 mode 3 as ECB", got, fe(64'h9999_8888_7777_6666, K1));
    rd(8, v); check("R11 saturating count", v, 32'h8000_0034);
    wr(9, 0);
    rd(8, v); check("R4 zero length no start", v, 32'h8000_0034);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_ecb_single();
    t_cbc_triple();
    t_cfb();
    t_ignore();
    t_partial();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule